// File: doc/BRIEF.md
# Shared Receive Silo with Character Alarm

This block is the receive queue that all serial lines of a multi-line controller share. Each received character is offered on a push port together with its 3-bit line number and a parity error flag. It is stored in a first-in, first-out store. Software takes characters out by reading a buffer word. Each read is destructive: it returns the oldest entry and removes it. The returned word has a valid bit, so a loop can keep reading until valid comes back as 0.

Two status outputs are produced. `done` means that a character is waiting at the head of the queue. `alarm` means that a set number of characters have been accepted since the last buffer read. Two enable inputs combine these into one interrupt request.

After each successful read, the next entry is hidden for a fixed number of clock cycles. This delay is a parameter, so it can be set to match a minimum access spacing in real time at the chosen clock frequency. A push into a full queue is dropped. The loss is flagged in the next word that is returned.

Top module: `rx_silo`

## Requirements
- R1: After reset, `done`, `alarm` and `irq` are 0 and `rd_word` is all zero.
- R2: A returned word has this layout: bit 15 valid, bit 14 overflow, bit 12 parity error, bits 10:8 line number, bits 7:0 data, and bits 13 and 11 zero.
- R3: A one-cycle `rd_en` pops the oldest entry, and its word appears on `rd_word` after that clock edge. Entries come out in push order.
- R4: `done` is 1 exactly when the queue holds at least one entry and no post-read hiding interval is running.
- R5: After a successful read, the next entry is hidden for the next GAP_CYCLES-1 cycles. A read made `GAP_CYCLES` cycles after the previous one returns the next entry. An earlier read returns valid 0 and removes nothing.
- R6: A read while `done` is 0 returns an all-zero word.
- R7: `alarm` is 1 once `ALARM_COUNT` pushes have been accepted since the last read or reset. Any read, valid or not, clears the count. A push in the same cycle as a read counts toward the new total.
- R8: A push while the queue holds `DEPTH` entries and no pop happens in that cycle is dropped. The next valid word returned then has bit 14 set, and later words have it clear. A push in the same cycle as a pop on a full queue is accepted.
- R9: `irq` is 0 while `rx_ie` is 0. With `rx_ie` 1 and `alarm_ie` 0 it follows `done`. With both set it follows `alarm`.
- R10: `rd_word` does not change in a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer one received character |
| push_data | input | 8 | Character data |
| push_line | input | 3 | Line the character came from |
| push_perr | input | 1 | Parity error on that character |
| rd_en | input | 1 | One-cycle buffer read strobe |
| rx_ie | input | 1 | Receive interrupt enable |
| alarm_ie | input | 1 | Select alarm instead of done as interrupt source |
| done | output | 1 | Character visible at queue head |
| alarm | output | 1 | Alarm count reached since last read |
| irq | output | 1 | Receive interrupt request |
| rd_word | output | 16 | Word returned by the last read |

## Verification
The assertions rely on three assumptions. `rd_en` is a strobe that stands for exactly one buffer access per high cycle. `DEPTH` is a power of two. `GAP_CYCLES` is at least 1. The bench drives every input at the falling edge for exactly one cycle, so each read and each push is one access. It uses a small configuration with depth 8, alarm count 6 and gap 4. This lets it fill the queue past capacity and read at every spacing from back-to-back up to beyond the gap.

// File: rtl/rx_silo.sv
module rx_silo #(
  parameter int DEPTH       = 64,
  parameter int ALARM_COUNT = 16,
  parameter int GAP_CYCLES  = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [7:0]  push_data,
  input  logic [2:0]  push_line,
  input  logic        push_perr,
  input  logic        rd_en,
  input  logic        rx_ie,
  input  logic        alarm_ie,
  output logic        done,
  output logic        alarm,
  output logic        irq,
  output logic [15:0] rd_word
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int KW = $clog2(ALARM_COUNT + 1);
  localparam int HW = $clog2(GAP_CYCLES + 1);

  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;
  logic [KW-1:0] acnt, acnt_base, acnt_nx;
  logic          ovf_pend;

  assign done  = (cnt != '0) && (hold == '0);
  wire   pop   = rd_en && done;
  wire   full  = (cnt == CW'(DEPTH));
  wire   accept = push_valid && (!full || pop);
  assign alarm = (acnt == KW'(ALARM_COUNT));
  assign irq   = rx_ie && (alarm_ie ? alarm : done);

  always_comb begin
    acnt_base = rd_en ? '0 : acnt;
    acnt_nx   = acnt_base;
    if (accept && acnt_base != KW'(ALARM_COUNT)) acnt_nx = acnt_base + 1'b1;
  end

  always_ff @(posedge clk)
    if (accept) mem[wp] <= {push_perr, push_line, push_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; hold <= '0;
      acnt <= '0; ovf_pend <= 1'b0; rd_word <= '0;
    end else begin
      if (accept) wp <= wp + 1'b1;
      if (pop)    rp <= rp + 1'b1;
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (pop)              hold <= HW'(GAP_CYCLES - 1);
      else if (hold != '0)  hold <= hold - 1'b1;
      acnt <= acnt_nx;
      if (pop) ovf_pend <= 1'b0;
      if (push_valid && !accept) ovf_pend <= 1'b1;
      if (rd_en)
        rd_word <= pop ? {1'b1, ovf_pend, 1'b0, mem[rp][11], 1'b0, mem[rp][10:0]} : 16'h0000;
    end
  end

  AST_POP_HIDES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && GAP_CYCLES > 1) |=> !done); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done) |=> (rd_word == 16'h0000)); // R6
  AST_READ_CLEARS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !push_valid) |=> !alarm); // R7
  AST_ALARM_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(accept)); // R7
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R8
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_word)); // R10
endmodule

// File: tb/rx_silo_test.sv
module rx_silo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int ALARM = 6;
  localparam int GAP   = 4;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_perr = 0, rd_en = 0, rx_ie = 0, alarm_ie = 0;
  logic [7:0] push_data = 0;
  logic [2:0] push_line = 0;
  logic done, alarm, irq;
  logic [15:0] rd_word;

  int vectors = 0, fails = 0;
  logic [11:0] q[$];
  logic [15:0] m_word = 0;
  logic m_ovf = 0;
  int m_hold = 0, m_acnt = 0;

  rx_silo #(.DEPTH(DEPTH), .ALARM_COUNT(ALARM), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_line(push_line), .push_perr(push_perr), .rd_en(rd_en), .rx_ie(rx_ie),
    .alarm_ie(alarm_ie), .done(done), .alarm(alarm), .irq(irq), .rd_word(rd_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic pv, input logic [7:0] d, input logic [2:0] l,
                     input logic p, input logic rd);
    logic m_done, m_pop, e_alarm, e_done;
    logic [11:0] e;
    @(negedge clk);
    push_valid = pv; push_data = d; push_line = l; push_perr = p; rd_en = rd;
    m_done = (q.size() != 0) && (m_hold == 0);
    m_pop  = rd && m_done;
    if (rd) begin
      m_acnt = 0;
      if (m_pop) begin
        e = q.pop_front();
        m_word = {1'b1, m_ovf, 1'b0, e[11], 1'b0, e[10:0]}; // R2 layout
        m_ovf = 0;
      end else m_word = 16'h0000; // R6
    end
    if (m_pop) m_hold = GAP - 1;
    else if (m_hold > 0) m_hold--;
    if (pv) begin
      if (q.size() < DEPTH) begin
        q.push_back({p, l, d});
        if (m_acnt < ALARM) m_acnt++;
      end else m_ovf = 1; // R8
    end
    @(posedge clk); #1;
    push_valid = 0; rd_en = 0;
    e_done  = (q.size() != 0) && (m_hold == 0);
    e_alarm = (m_acnt == ALARM);
    check("R4 done", {15'd0, done}, {15'd0, e_done});
    check("R7 alarm", {15'd0, alarm}, {15'd0, e_alarm});
    check("R9 irq", {15'd0, irq}, {15'd0, rx_ie && (alarm_ie ? e_alarm : e_done)});
    check("R3 rd_word", rd_word, m_word); // also R5, R8, R10
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 2; i++) begin
      cyc(0, 0, 0, 0, 1);
      idle(GAP);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R3 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 alarm", {15'd0, alarm}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 rd_word", rd_word, 16'd0);

    // R2 R3: every line and parity value, two rounds
    rx_ie = 1; alarm_ie = 0;
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 8; i++) cyc(1, 8'(i * 37 + r * 91 + 1), 3'(i), 1'(i + r), 0);
      // R5: read spacing sweep from back-to-back to beyond the gap
      for (int k = 0; k <= GAP + 1; k++) begin
        cyc(0, 0, 0, 0, 1);
        idle(k);
      end
      drain();
    end

    // R6 read on empty queue
    cyc(0, 0, 0, 0, 1);
    idle(2);

    // R8 overflow: fill and push beyond
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 8'(200 + i), 3'(7 - i), 0, 0);
    drain();
    // R8 push and pop together on full queue
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i), 3'(i), 1, 0);
    cyc(1, 8'hAA, 3'd5, 0, 1);
    cyc(1, 8'hBB, 3'd6, 1, 0);
    drain();

    // R7 R9: alarm under every enable combination
    for (int c = 0; c < 4; c++) begin
      rx_ie = c[0]; alarm_ie = c[1];
      for (int i = 0; i < ALARM - 1; i++) cyc(1, 8'(c * 16 + i), 3'(c), 0, 0);
      idle(1);
      cyc(1, 8'hC0, 3'd1, 0, 0);
      idle(2);
      cyc(1, 8'hC1, 3'd2, 1, 1);
      idle(GAP);
      drain();
      cyc(0, 0, 0, 0, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule